// File: doc/BRIEF.md
# Multi-Level Sleep Mode Controller

This block sequences a small microcontroller between an active state and five sleep levels: idle, standby, hibernate, backup and off. Software writes a sleep-level field through a simple register port. When the CPU signals a wait-for-interrupt, the controller enters the level in effect. A regulator-ready input holds back the three regulator-dependent levels until the main regulator's low-power mode has settled.

While asleep, the controller drives gated enables for the main, CPU, bus and generic clocks, and one enable per oscillator. It also drives coded regulator and NVM mode outputs. Each level accepts only its own wake sources. The shallow levels wake on interrupts. Hibernate, backup and off leave only through their own reset, and that exit also pulses a reset-request output.

Top module: `psm_sleep_ctrl`

## Requirements
- R1: After reset, `power_state` is 0 (active), all four clock enables are 1, `vreg_mode` and `nvm_mode` are 0, `cfg_rdata` is 0 and `rst_req` is 0.
- R2: A write to the level field is returned by `cfg_rdata` and governs entry on the second rising edge after the edge that samples `cfg_we`. Before then, the old value is read and used.
- R3: With `wfi` high in active, the next edge moves `power_state` to the level in effect. Field codes are 0 idle, 1 standby, 2 hibernate, 3 backup and 4 off. State codes are 0 active, 1 idle, 2 standby, 3 hibernate, 4 backup and 5 off.
- R4: While `vreg_rdy` is 0, a `wfi` requesting standby, hibernate or backup leaves the controller active. Off is still entered.
- R5: Field codes 5 to 7 enter idle.
- R6: In idle, main and generic clocks run and the CPU clock is off. The bus clock follows `sleepwalk`. Regulator and NVM stay at mode 0. `wake_sync` or `wake_async` returns to active on the next edge.
- R7: In standby, main, CPU and bus clocks are off and the generic clock follows `sleepwalk`. `vreg_mode` is 1 (main, low power) and `nvm_mode` is 1 (ultra-low power). Only `wake_async` or `wake_stdby` wake; `wake_sync` alone is ignored.
- R8: In hibernate, all clocks and oscillators are off, `vreg_mode` is 1 and `nvm_mode` is 2 (deepest retention). Only `rst_hib` exits; interrupt wakes are ignored.
- R9: In backup, all clocks and oscillators are off, `vreg_mode` is 2 (backup regulator) and `nvm_mode` is 3 (off). Only `rst_bkp` exits.
- R10: In off, all clocks and oscillators are off, `vreg_mode` is 3 and `nvm_mode` is 3. Only `rst_ext` exits.
- R11: A reset-type exit sets `rst_req` high for exactly the first active cycle. An interrupt wake never sets it.
- R12: Per oscillator: with on-demand set, it runs only while requested. With on-demand clear, it runs in active and idle; in standby it runs if requested or if its run-in-standby bit is set. Deeper levels turn every oscillator off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Level field write strobe |
| cfg_wdata | input | 3 | Level field write data |
| cfg_rdata | output | 3 | Level field value in effect |
| wfi | input | 1 | CPU wait-for-interrupt strobe |
| vreg_rdy | input | 1 | Main regulator low-power mode settled |
| wake_sync | input | 1 | Bus-clocked interrupt |
| wake_stdby | input | 1 | Bus-clocked interrupt from a peripheral enabled in standby |
| wake_async | input | 1 | Asynchronous interrupt |
| rst_hib | input | 1 | Hibernate reset detected |
| rst_bkp | input | 1 | Backup reset detected |
| rst_ext | input | 1 | External reset detected |
| sleepwalk | input | 1 | A peripheral is working during sleep |
| osc_req | input | 4 | Per-oscillator peripheral request |
| osc_ondemand | input | 4 | Per-oscillator on-demand mode |
| osc_runstdby | input | 4 | Per-oscillator run-in-standby |
| main_clk_en | output | 1 | Main clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| gclk_en | output | 1 | Generic clocks enable |
| osc_en | output | 4 | Per-oscillator enable |
| vreg_mode | output | 2 | 0 main, 1 main low power, 2 backup, 3 off |
| nvm_mode | output | 2 | 0 normal, 1 ultra-low, 2 deepest retention, 3 off |
| rst_req | output | 1 | One-cycle reset request on reset-type exit |
| power_state | output | 3 | Current state code |

## Verification
Each sleep level is entered and then offered every wake input in turn. Inputs that must not wake are applied first, so an over-permissive qualification shows up as an early return to active. A wrong source mapping shows up as a level that never leaves.

Entry is tried with the regulator flag low and high, with each defined field code and with an undefined code. This separates a correct refusal from a wrong level decode.

A write followed at once by a `wfi` distinguishes the two-cycle bridge delay from a shorter one. The oscillator inputs mix on-demand, request and run-in-standby bits, so that each branch of the per-oscillator rule drives a different bit.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_IDLE   = 3'd1,
        ST_STDBY  = 3'd2,
        ST_HIB    = 3'd3,
        ST_BKP    = 3'd4,
        ST_OFF    = 3'd5
    } pwr_state_e;

    localparam logic [MODE_W-1:0] CFG_IDLE  = 3'd0;
    localparam logic [MODE_W-1:0] CFG_STDBY = 3'd1;
    localparam logic [MODE_W-1:0] CFG_HIB   = 3'd2;
    localparam logic [MODE_W-1:0] CFG_BKP   = 3'd3;
    localparam logic [MODE_W-1:0] CFG_OFF   = 3'd4;

    localparam logic [1:0] VREG_MAIN   = 2'd0;
    localparam logic [1:0] VREG_LP     = 2'd1;
    localparam logic [1:0] VREG_BACKUP = 2'd2;
    localparam logic [1:0] VREG_OFF    = 2'd3;

    localparam logic [1:0] NVM_NORMAL = 2'd0;
    localparam logic [1:0] NVM_ULP    = 2'd1;
    localparam logic [1:0] NVM_ULPP   = 2'd2;
    localparam logic [1:0] NVM_OFF    = 2'd3;

    typedef struct packed {
        logic       main_en;
        logic       cpu_en;
        logic       bus_en;
        logic       gclk_en;
        logic [1:0] vreg;
        logic [1:0] nvm;
    } gate_ctl_t;

    // Field code to target sleep state; unknown codes fall back to idle.
    function automatic pwr_state_e cfg_to_state(input logic [MODE_W-1:0] code);
        case (code)
            CFG_STDBY: return ST_STDBY;
            CFG_HIB:   return ST_HIB;
            CFG_BKP:   return ST_BKP;
            CFG_OFF:   return ST_OFF;
            default:   return ST_IDLE;
        endcase
    endfunction

    function automatic logic needs_vreg(input pwr_state_e s);
        return (s == ST_STDBY) || (s == ST_HIB) || (s == ST_BKP);
    endfunction

endpackage

// File: rtl/slp_cfg_bridge.sv
module slp_cfg_bridge
    import slp_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] eff
);
    logic [MODE_W-1:0] val_q [DEPTH];
    logic              vld_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        val_q[0] <= '0;
                        vld_q[0] <= 1'b0;
                    end else begin
                        val_q[0] <= wdata;
                        vld_q[0] <= we;
                    end
                end
            end else if (i == DEPTH - 1) begin : g_last
                always_ff @(posedge clk) begin
                    if (rst) begin
                        val_q[i] <= CFG_IDLE;
                        vld_q[i] <= 1'b0;
                    end else begin
                        vld_q[i] <= 1'b0;
                        if (vld_q[i-1]) val_q[i] <= val_q[i-1];
                    end
                end
            end else begin : g_mid
                always_ff @(posedge clk) begin
                    if (rst) begin
                        val_q[i] <= '0;
                        vld_q[i] <= 1'b0;
                    end else begin
                        val_q[i] <= val_q[i-1];
                        vld_q[i] <= vld_q[i-1];
                    end
                end
            end
        end
    endgenerate

    assign eff = val_q[DEPTH-1];

    // R2: a sampled write lands in the field two edges later
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> ##1 (eff == $past(wdata, 2)));

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wfi,
    input  logic              vreg_rdy,
    input  logic [MODE_W-1:0] cfg_eff,
    input  logic              wake_sync,
    input  logic              wake_stdby,
    input  logic              wake_async,
    input  logic              rst_hib,
    input  logic              rst_bkp,
    input  logic              rst_ext,
    output pwr_state_e        state,
    output logic              rst_req
);
    pwr_state_e st_q, st_d, target;
    logic       reset_exit;
    logic       irq_exit;

    assign target = cfg_to_state(cfg_eff);

    always_comb begin
        reset_exit = 1'b0;
        irq_exit   = 1'b0;
        case (st_q)
            ST_IDLE:  irq_exit   = wake_sync | wake_async;
            ST_STDBY: irq_exit   = wake_stdby | wake_async;
            ST_HIB:   reset_exit = rst_hib;
            ST_BKP:   reset_exit = rst_bkp;
            ST_OFF:   reset_exit = rst_ext;
            default:  ;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (st_q == ST_ACTIVE) begin
            if (wfi && !(needs_vreg(target) && !vreg_rdy)) st_d = target;
        end else if (irq_exit || reset_exit) begin
            st_d = ST_ACTIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_ACTIVE;
            rst_req <= 1'b0;
        end else begin
            st_q    <= st_d;
            rst_req <= reset_exit;
        end
    end

    assign state = st_q;

    // R4: regulator-dependent levels are refused while not ready
    p_vreg_refuse_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACTIVE && wfi && !vreg_rdy && needs_vreg(target)) |=> (st_q == ST_ACTIVE));

    // R8: hibernate holds without its reset
    p_hib_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HIB && !rst_hib) |=> (st_q == ST_HIB));

    // R9: backup holds without its reset
    p_bkp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BKP && !rst_bkp) |=> (st_q == ST_BKP));

    // R10: off holds without external reset
    p_off_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OFF && !rst_ext) |=> (st_q == ST_OFF));

    // R11: reset request only on the first active cycle after a deep exit
    p_rst_req_r11: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (st_q == ST_ACTIVE) && ($past(st_q) inside {ST_HIB, ST_BKP, ST_OFF}));

endmodule

// File: rtl/slp_gate.sv
module slp_gate
    import slp_pkg::*;
#(
    parameter int N_OSC = 4
) (
    input  pwr_state_e       state,
    input  logic             sleepwalk,
    input  logic [N_OSC-1:0] osc_req,
    input  logic [N_OSC-1:0] osc_ondemand,
    input  logic [N_OSC-1:0] osc_runstdby,
    output gate_ctl_t        ctl,
    output logic [N_OSC-1:0] osc_en
);
    always_comb begin
        ctl = '{main_en: 1'b0, cpu_en: 1'b0, bus_en: 1'b0, gclk_en: 1'b0,
                vreg: VREG_MAIN, nvm: NVM_NORMAL};
        case (state)
            ST_ACTIVE: begin
                ctl.main_en = 1'b1;
                ctl.cpu_en  = 1'b1;
                ctl.bus_en  = 1'b1;
                ctl.gclk_en = 1'b1;
            end
            ST_IDLE: begin
                ctl.main_en = 1'b1;
                ctl.bus_en  = sleepwalk;
                ctl.gclk_en = 1'b1;
            end
            ST_STDBY: begin
                ctl.gclk_en = sleepwalk;
                ctl.vreg    = VREG_LP;
                ctl.nvm     = NVM_ULP;
            end
            ST_HIB: begin
                ctl.vreg = VREG_LP;
                ctl.nvm  = NVM_ULPP;
            end
            ST_BKP: begin
                ctl.vreg = VREG_BACKUP;
                ctl.nvm  = NVM_OFF;
            end
            default: begin
                ctl.vreg = VREG_OFF;
                ctl.nvm  = NVM_OFF;
            end
        endcase
    end

    generate
        for (genvar i = 0; i < N_OSC; i++) begin : g_osc
            always_comb begin
                case (state)
                    ST_ACTIVE, ST_IDLE:
                        osc_en[i] = osc_ondemand[i] ? osc_req[i] : 1'b1;
                    ST_STDBY:
                        osc_en[i] = osc_req[i] | (~osc_ondemand[i] & osc_runstdby[i]);
                    default:
                        osc_en[i] = 1'b0;
                endcase
            end
        end
    endgenerate

    // R6: CPU clock never runs outside active
    always_comb begin
        p_cpu_gated_r6: assert (state == ST_ACTIVE || !ctl.cpu_en);
    end

    // R8: levels below standby keep every oscillator off
    always_comb begin
        p_osc_dark_r8: assert (!(state inside {ST_HIB, ST_BKP, ST_OFF}) || osc_en == '0);
    end

endmodule

// File: rtl/psm_sleep_ctrl.sv
module psm_sleep_ctrl
    import slp_pkg::*;
#(
    parameter int N_OSC = 4,
    parameter int BRIDGE_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_wdata,
    output logic [2:0]       cfg_rdata,
    input  logic             wfi,
    input  logic             vreg_rdy,
    input  logic             wake_sync,
    input  logic             wake_stdby,
    input  logic             wake_async,
    input  logic             rst_hib,
    input  logic             rst_bkp,
    input  logic             rst_ext,
    input  logic             sleepwalk,
    input  logic [N_OSC-1:0] osc_req,
    input  logic [N_OSC-1:0] osc_ondemand,
    input  logic [N_OSC-1:0] osc_runstdby,
    output logic             main_clk_en,
    output logic             cpu_clk_en,
    output logic             bus_clk_en,
    output logic             gclk_en,
    output logic [N_OSC-1:0] osc_en,
    output logic [1:0]       vreg_mode,
    output logic [1:0]       nvm_mode,
    output logic             rst_req,
    output logic [2:0]       power_state
);
    logic [MODE_W-1:0] cfg_eff;
    pwr_state_e        state;
    gate_ctl_t         ctl;

    slp_cfg_bridge #(.DEPTH(BRIDGE_DELAY)) u_bridge (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .eff   (cfg_eff)
    );

    slp_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wfi        (wfi),
        .vreg_rdy   (vreg_rdy),
        .cfg_eff    (cfg_eff),
        .wake_sync  (wake_sync),
        .wake_stdby (wake_stdby),
        .wake_async (wake_async),
        .rst_hib    (rst_hib),
        .rst_bkp    (rst_bkp),
        .rst_ext    (rst_ext),
        .state      (state),
        .rst_req    (rst_req)
    );

    slp_gate #(.N_OSC(N_OSC)) u_gate (
        .state        (state),
        .sleepwalk    (sleepwalk),
        .osc_req      (osc_req),
        .osc_ondemand (osc_ondemand),
        .osc_runstdby (osc_runstdby),
        .ctl          (ctl),
        .osc_en       (osc_en)
    );

    assign cfg_rdata   = cfg_eff;
    assign main_clk_en = ctl.main_en;
    assign cpu_clk_en  = ctl.cpu_en;
    assign bus_clk_en  = ctl.bus_en;
    assign gclk_en     = ctl.gclk_en;
    assign vreg_mode   = ctl.vreg;
    assign nvm_mode    = ctl.nvm;
    assign power_state = state;

endmodule

// File: tb/sim_psm_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_psm_sleep_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, wfi = 0, vreg_rdy = 0;
    logic [2:0] cfg_wdata = 0, cfg_rdata;
    logic wake_sync = 0, wake_stdby = 0, wake_async = 0;
    logic rst_hib = 0, rst_bkp = 0, rst_ext = 0, sleepwalk = 0;
    logic [3:0] osc_req = 0, osc_ondemand = 0, osc_runstdby = 0, osc_en;
    logic main_clk_en, cpu_clk_en, bus_clk_en, gclk_en, rst_req;
    logic [1:0] vreg_mode, nvm_mode;
    logic [2:0] power_state;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    psm_sleep_ctrl u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clks();
        return {main_clk_en, cpu_clk_en, bus_clk_en, gclk_en};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        cfg_we = 1; cfg_wdata = m;
        step();
        cfg_we = 0;
        step();
    endtask

    task automatic do_wfi();
        wfi = 1;
        step();
        wfi = 0;
    endtask

    task automatic pulse(ref logic s);
        s = 1;
        step();
        s = 0;
    endtask

    task automatic t_reset();
        check("R1 state", power_state, 0);
        check("R1 clocks", clks(), 4'b1111);
        check("R1 vreg", vreg_mode, 0);
        check("R1 nvm", nvm_mode, 0);
        check("R1 rdata", cfg_rdata, 0);
        check("R1 rst_req", rst_req, 0);
    endtask

    task automatic t_cfg_delay();
        cfg_we = 1; cfg_wdata = 3'd1;
        step();
        cfg_we = 0;
        check("R2 old after 1", cfg_rdata, 0);
        wfi = 1;
        step();
        wfi = 0;
        check("R2 old value used", power_state, 1);
        check("R2 new after 2", cfg_rdata, 1);
        pulse(wake_async);
        check("R6 async wake", power_state, 0);
    endtask

    task automatic t_idle();
        set_mode(3'd0);
        sleepwalk = 0;
        do_wfi();
        check("R3 idle entry", power_state, 1);
        check("R6 idle clocks", clks(), 4'b1001);
        sleepwalk = 1;
        #1 check("R6 idle bus walk", bus_clk_en, 1);
        sleepwalk = 0;
        pulse(rst_hib);
        check("R6 idle ignores hib", power_state, 1);
        pulse(wake_sync);
        check("R6 sync wake", power_state, 0);
        check("R11 no req on irq", rst_req, 0);
    endtask

    task automatic t_refuse();
        vreg_rdy = 0;
        for (int m = 1; m <= 3; m++) begin
            set_mode(m[2:0]);
            do_wfi();
            check("R4 refused", power_state, 0);
        end
    endtask

    task automatic t_standby();
        vreg_rdy = 1;
        set_mode(3'd1);
        sleepwalk = 1;
        do_wfi();
        check("R3 standby entry", power_state, 2);
        check("R7 clocks walk", clks(), 4'b0001);
        sleepwalk = 0;
        #1 check("R7 clocks", clks(), 4'b0000);
        check("R7 vreg", vreg_mode, 1);
        check("R7 nvm", nvm_mode, 1);
        pulse(wake_sync);
        check("R7 sync ignored", power_state, 2);
        pulse(wake_stdby);
        check("R7 stdby wake", power_state, 0);
    endtask

    task automatic t_hib();
        set_mode(3'd2);
        do_wfi();
        check("R3 hib entry", power_state, 3);
        check("R8 clocks", clks(), 0);
        check("R8 vreg", vreg_mode, 1);
        check("R8 nvm", nvm_mode, 2);
        pulse(wake_async);
        pulse(rst_bkp);
        check("R8 ignores others", power_state, 3);
        check("R11 no req", rst_req, 0);
        pulse(rst_hib);
        check("R8 exit", power_state, 0);
        check("R11 req pulse", rst_req, 1);
        step();
        check("R11 req one cycle", rst_req, 0);
    endtask

    task automatic t_bkp();
        set_mode(3'd3);
        do_wfi();
        check("R3 bkp entry", power_state, 4);
        check("R9 vreg", vreg_mode, 2);
        check("R9 nvm", nvm_mode, 3);
        check("R9 clocks", clks(), 0);
        pulse(rst_hib);
        pulse(rst_ext);
        check("R9 ignores others", power_state, 4);
        pulse(rst_bkp);
        check("R9 exit", power_state, 0);
        check("R11 bkp req", rst_req, 1);
    endtask

    task automatic t_off();
        vreg_rdy = 0;
        set_mode(3'd4);
        do_wfi();
        check("R4 off allowed", power_state, 5);
        check("R10 vreg", vreg_mode, 3);
        check("R10 nvm", nvm_mode, 3);
        pulse(wake_async);
        pulse(rst_bkp);
        check("R10 ignores others", power_state, 5);
        pulse(rst_ext);
        check("R10 exit", power_state, 0);
        check("R11 ext req", rst_req, 1);
        vreg_rdy = 1;
    endtask

    task automatic t_undef();
        for (int m = 5; m <= 7; m++) begin
            set_mode(m[2:0]);
            do_wfi();
            check("R5 undef is idle", power_state, 1);
            pulse(wake_async);
        end
    endtask

    task automatic t_osc();
        osc_ondemand = 4'b0011; osc_req = 4'b0101; osc_runstdby = 4'b1000;
        #1 check("R12 active", osc_en, 4'b1101);
        vreg_rdy = 1;
        set_mode(3'd1);
        do_wfi();
        check("R12 standby", osc_en, 4'b1101);
        osc_req = 4'b0001;
        #1 check("R12 standby low req", osc_en, 4'b1001);
        pulse(wake_async);
        set_mode(3'd2);
        do_wfi();
        check("R12 hib off", osc_en, 0);
        pulse(rst_hib);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_cfg_delay();
        t_idle();
        t_refuse();
        t_standby();
        t_hib();
        t_bkp();
        t_off();
        t_undef();
        t_osc();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule